// File: doc/BRIEF.md
# Partial-Display Common Scan Sequencer

This block drives the common (row) lines of a dot-matrix LCD while the panel runs in its reduced partial-display mode. In that mode only one eight-line window of the 80 common lines is scanned. Each scan period selects one line of the window, and a frame is eight scan periods long (1/8 duty). Every other line stays at the unselected level. A 4-bit position code picks one of ten windows, and a direction bit sets the order in which the window is walked.

The lower five windows cover common lines 1 to 40 in ascending groups of eight. The upper five windows start at line 80 and step downwards. The scan clock in partial mode is one tenth of the main clock, produced as a one-cycle enable. The mode may only start while the external drive supply is reported off, so the enable is qualified by that status. A 3-bit contrast code is registered and passed on while the mode is active.

The block has no streaming data path. Every pin is a plain level-sensitive control or status signal, so there is no valid/ready handshake and no back-pressure. Output bit n of the line vectors corresponds to common line n+1.

Top module: `pscan_seq`

## Requirements
- R1: While the synchronous active-high reset is applied, and in the cycle after it, the outputs com_sel, com_lvl, frame_start, scan_en and contrast_q are all zero.
- R2: Partial mode is active only while both part_en and pwr_off are 1. Raising part_en with pwr_off at 0 leaves every output line deselected and scan_en low. Dropping part_en deselects all lines one clock later.
- R3: While partial mode is active, scan_en is high for exactly one main clock in every 10. The first pulse comes in the tenth cycle after entry.
- R4: While partial mode is active, exactly one bit of com_sel is high. It moves to the next line of the window on each scan_en pulse and wraps after eight lines.
- R5: With dir_up=1, codes 0, 1, 2, 3 and 4 scan common lines 1→8, 9→16, 17→24, 25→32 and 33→40 respectively.
- R6: With dir_up=1, codes 5, 6, 7, 8 and 9 scan common lines 80→73, 72→65, 64→57, 56→49 and 48→41 respectively.
- R7: With dir_up=0, each window is walked in the opposite order. For example, code 0 scans 8→1 and code 5 scans 73→80.
- R8: While partial mode is active, com_lvl is 1 on exactly the eight lines of the current window for the whole frame, and 0 on all other lines.
- R9: A blk_code value of 10 to 15 is ignored. The last valid code stays in force, both while idle and during a frame.
- R10: A change of blk_code or dir_up takes effect only at the start of the next frame. A frame never mixes two windows.
- R11: frame_start is 1 for the whole scan period in which the first line of the window is selected, and 0 during the other seven.
- R12: contrast_q follows contrast one clock later while partial mode is active, and reads 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst | input | 1 | Synchronous reset, active high |
| part_en | input | 1 | Partial-mode request |
| pwr_off | input | 1 | External drive supply reported off |
| blk_code | input | 4 | Window position code, 0 to 9 valid |
| dir_up | input | 1 | Window scan direction |
| contrast | input | 3 | Contrast level code |
| com_sel | output | 80 | One-hot select of the line being scanned |
| com_lvl | output | 80 | 1 = line driven at selected levels this frame |
| frame_start | output | 1 | High during the first scan period of a frame |
| scan_en | output | 1 | Divide-by-10 scan-clock enable |
| contrast_q | output | 3 | Registered contrast code |

## Verification
The bench walks all twenty code and direction pairs through full frames. A decoder that mishandled the non-monotonic upper half would light lines 41 to 48 for code 5, or walk code 9 upwards. The bench changes the code and the direction mid-frame and then sends an invalid code. A design without the frame-boundary latch would jump windows partway through a frame, and one that accepted codes above 9 would select no line or a wrong one. The bench also requests the mode with the supply still on, and counts scan enables over a hundred clocks, which catches an off-by-one divider or missing power gating.

// File: rtl/pscan_pkg.sv
package pscan_pkg;
  localparam int BLK_W = 4;
  typedef logic [BLK_W-1:0] blk_t;
endpackage

// File: rtl/pscan_clkdiv.sv
module pscan_clkdiv #(
  parameter int DIV_RATIO = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CNT_W = (DIV_RATIO > 1) ? $clog2(DIV_RATIO) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV_RATIO - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == LAST);

  generate
    if (DIV_RATIO > 1) begin : g_gap
      a_r3_tick_gap: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
      a_r3_no_early_tick: assert property (@(posedge clk) disable iff (rst)
        $rose(run) |-> !tick);
    end
  endgenerate
endmodule

// File: rtl/pscan_ctrl.sv
module pscan_ctrl
  import pscan_pkg::*;
#(
  parameter int NUM_BLK  = 10,
  parameter int WIN_ROWS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic part_en,
  input  logic pwr_off,
  input  blk_t blk_code,
  input  logic dir_up,
  input  logic tick,
  output logic mode_act,
  output blk_t blk_cur,
  output logic dir_cur,
  output logic [((WIN_ROWS > 1) ? $clog2(WIN_ROWS) : 1)-1:0] row
);
  localparam int ROW_W = (WIN_ROWS > 1) ? $clog2(WIN_ROWS) : 1;
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(WIN_ROWS - 1);
  localparam blk_t NUM_BLK_B = BLK_W'(NUM_BLK);

  blk_t blk_pend, pend_nx;
  logic frame_end, load_win;

  always_comb begin
    pend_nx = (blk_code < NUM_BLK_B) ? blk_code : blk_pend;
  end

  assign frame_end = tick && (row == ROW_LAST);
  assign load_win  = !mode_act || frame_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_act <= 1'b0;
      blk_pend <= '0;
      blk_cur  <= '0;
      dir_cur  <= 1'b1;
      row      <= '0;
    end else begin
      mode_act <= part_en && pwr_off;
      blk_pend <= pend_nx;
      if (load_win) begin
        blk_cur <= pend_nx;
        dir_cur <= dir_up;
      end
      if (!mode_act) row <= '0;
      else if (tick) row <= (row == ROW_LAST) ? '0 : row + 1'b1;
    end
  end

  a_r2_entry_needs_power_off: assert property (@(posedge clk) disable iff (rst)
    $rose(mode_act) |-> $past(pwr_off) && $past(part_en));
  a_r9_window_code_valid: assert property (@(posedge clk) disable iff (rst)
    blk_cur < NUM_BLK_B);
  a_r10_window_held_in_frame: assert property (@(posedge clk) disable iff (rst)
    (mode_act && $past(mode_act) && !$past(frame_end))
      |-> ($stable(blk_cur) && $stable(dir_cur)));
  a_r4_row_held_between_ticks: assert property (@(posedge clk) disable iff (rst)
    (mode_act && $past(mode_act) && !$past(tick)) |-> $stable(row));
endmodule

// File: rtl/pscan_decode.sv
module pscan_decode
  import pscan_pkg::*;
#(
  parameter int NUM_LINES = 80,
  parameter int WIN_ROWS  = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic act,
  input  blk_t blk,
  input  logic dir,
  input  logic [((WIN_ROWS > 1) ? $clog2(WIN_ROWS) : 1)-1:0] row,
  output logic [NUM_LINES-1:0] com_sel,
  output logic [NUM_LINES-1:0] com_lvl
);
  localparam int NUM_BLK = NUM_LINES / WIN_ROWS;
  localparam int HALF    = NUM_BLK / 2;

  int blk_i, idx_i, line_i, lo_i;

  always_comb begin
    blk_i = int'(blk);
    idx_i = dir ? int'(row) : (WIN_ROWS - 1 - int'(row));
    if (blk_i < HALF) begin
      lo_i   = blk_i * WIN_ROWS;
      line_i = lo_i + idx_i;
    end else begin
      lo_i   = NUM_LINES - (blk_i - HALF + 1) * WIN_ROWS;
      line_i = NUM_LINES - 1 - (blk_i - HALF) * WIN_ROWS - idx_i;
    end
  end

  generate
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      assign com_sel[i] = act && (line_i == i);
      assign com_lvl[i] = act && (i >= lo_i) && (i < lo_i + WIN_ROWS);
    end
  endgenerate

  a_r4_single_line: assert property (@(posedge clk) disable iff (rst)
    act |-> ($countones(com_sel) == 1));
  a_r8_window_width: assert property (@(posedge clk) disable iff (rst)
    act |-> ($countones(com_lvl) == WIN_ROWS));
  a_r8_sel_inside_window: assert property (@(posedge clk) disable iff (rst)
    (com_sel & ~com_lvl) == '0);
  a_r2_dark_when_idle: assert property (@(posedge clk) disable iff (rst)
    !act |-> ($onehot0(com_sel) && (com_lvl == '0)));
endmodule

// File: rtl/pscan_seq.sv
module pscan_seq
  import pscan_pkg::*;
#(
  parameter int NUM_LINES = 80,
  parameter int WIN_ROWS  = 8,
  parameter int DIV_RATIO = 10,
  parameter int CON_W     = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 part_en,
  input  logic                 pwr_off,
  input  logic [BLK_W-1:0]     blk_code,
  input  logic                 dir_up,
  input  logic [CON_W-1:0]     contrast,
  output logic [NUM_LINES-1:0] com_sel,
  output logic [NUM_LINES-1:0] com_lvl,
  output logic                 frame_start,
  output logic                 scan_en,
  output logic [CON_W-1:0]     contrast_q
);
  localparam int NUM_BLK = NUM_LINES / WIN_ROWS;
  localparam int ROW_W   = (WIN_ROWS > 1) ? $clog2(WIN_ROWS) : 1;

  logic             mode_act;
  blk_t             blk_cur;
  logic             dir_cur;
  logic [ROW_W-1:0] row;

  pscan_clkdiv #(.DIV_RATIO(DIV_RATIO)) u_div (
    .clk  (clk),
    .rst  (rst),
    .run  (mode_act),
    .tick (scan_en)
  );

  pscan_ctrl #(.NUM_BLK(NUM_BLK), .WIN_ROWS(WIN_ROWS)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .part_en  (part_en),
    .pwr_off  (pwr_off),
    .blk_code (blk_code),
    .dir_up   (dir_up),
    .tick     (scan_en),
    .mode_act (mode_act),
    .blk_cur  (blk_cur),
    .dir_cur  (dir_cur),
    .row      (row)
  );

  pscan_decode #(.NUM_LINES(NUM_LINES), .WIN_ROWS(WIN_ROWS)) u_dec (
    .clk     (clk),
    .rst     (rst),
    .act     (mode_act),
    .blk     (blk_cur),
    .dir     (dir_cur),
    .row     (row),
    .com_sel (com_sel),
    .com_lvl (com_lvl)
  );

  assign frame_start = mode_act && (row == '0);

  always_ff @(posedge clk) begin
    if (rst) contrast_q <= '0;
    else     contrast_q <= mode_act ? contrast : '0;
  end

  a_r11_frame_start_once: assert property (@(posedge clk) disable iff (rst)
    (frame_start && scan_en) |=> !frame_start);
  a_r12_contrast_zero_idle: assert property (@(posedge clk) disable iff (rst)
    (!mode_act && !$past(mode_act)) |-> (contrast_q == '0));
endmodule

// File: tb/tb_pscan_seq.sv
`timescale 1ns/1ps
module tb_pscan_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        part_en = 1'b0;
  logic        pwr_off = 1'b0;
  logic [3:0]  blk_code = 4'd0;
  logic        dir_up = 1'b1;
  logic [2:0]  contrast = 3'd0;
  logic [79:0] com_sel, com_lvl;
  logic        frame_start, scan_en;
  logic [2:0]  contrast_q;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pscan_seq dut (
    .clk(clk), .rst(rst), .part_en(part_en), .pwr_off(pwr_off),
    .blk_code(blk_code), .dir_up(dir_up), .contrast(contrast),
    .com_sel(com_sel), .com_lvl(com_lvl), .frame_start(frame_start),
    .scan_en(scan_en), .contrast_q(contrast_q)
  );

  // code, dir, first common line (1-based), step
  localparam int VEC [20][4] = '{
    '{0,1, 1, 1}, '{1,1, 9, 1}, '{2,1,17, 1}, '{3,1,25, 1}, '{4,1,33, 1},
    '{5,1,80,-1}, '{6,1,72,-1}, '{7,1,64,-1}, '{8,1,56,-1}, '{9,1,48,-1},
    '{0,0, 8,-1}, '{1,0,16,-1}, '{2,0,24,-1}, '{3,0,32,-1}, '{4,0,40,-1},
    '{5,0,73, 1}, '{6,0,65, 1}, '{7,0,57, 1}, '{8,0,49, 1}, '{9,0,41, 1}
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [79:0] one_line(input int line);
    return 80'd1 << (line - 1);
  endfunction

  function automatic logic [79:0] win_mask(input int first, input int stp);
    int lo;
    lo = (stp > 0) ? first : first + 7 * stp;
    return 80'hFF << (lo - 1);
  endfunction

  // leaves the bench at the first negedge after the entry edge
  task automatic enter(input int code, input bit dir);
    part_en = 1'b0;
    step(2);
    blk_code = 4'(code);
    dir_up = dir;
    pwr_off = 1'b1;
    part_en = 1'b1;
    step(1);
  endtask

  initial begin
    step(3);
    chk("R1 sel in reset", com_sel, '0);
    chk("R1 lvl in reset", com_lvl, '0);
    rst = 1'b0;
    step(1);
    chk("R1 after reset", {frame_start, scan_en, contrast_q, com_sel[0]}, '0);

    // table walk: R5 R6 R7 R8 R11
    for (int v = 0; v < 20; v++) begin
      enter(VEC[v][0], VEC[v][1] != 0);
      step(5);
      for (int r = 0; r < 8; r++) begin
        if (r > 0) step(10);
        chk((VEC[v][0] < 5) ? (VEC[v][1] != 0 ? "R5 line" : "R7 line")
                            : (VEC[v][1] != 0 ? "R6 line" : "R7 line"),
            com_sel, one_line(VEC[v][2] + r * VEC[v][3]));
        chk("R8 window", com_lvl, win_mask(VEC[v][2], VEC[v][3]));
        chk("R11 frame_start", 80'(frame_start), 80'(r == 0));
      end
      step(10);
      chk("R4 wrap", com_sel, one_line(VEC[v][2]));
    end

    // R3: divider rate and first pulse position
    begin
      int cnt = 0;
      int first = -1;
      enter(1, 1'b1);
      for (int k = 0; k < 100; k++) begin
        if (scan_en) begin
          cnt++;
          if (first < 0) first = k;
        end
        step(1);
      end
      chk("R3 pulse count", 80'(cnt), 80'd10);
      chk("R3 first pulse", 80'(first), 80'd9);
    end

    // R10 and R9 during a frame
    enter(3, 1'b1);
    step(25);
    blk_code = 4'd6;
    dir_up = 1'b0;
    step(10);
    chk("R10 row3 old window", com_sel, one_line(28));
    step(40);
    chk("R10 row7 old window", com_sel, one_line(32));
    chk("R10 old window mask", com_lvl, win_mask(25, 1));
    step(10);
    chk("R10 new window at frame", com_sel, one_line(65));
    chk("R11 new frame start", 80'(frame_start), 80'd1);
    blk_code = 4'd13;
    step(80);
    chk("R9 invalid ignored row0", com_sel, one_line(65));
    step(10);
    chk("R9 invalid ignored row1", com_sel, one_line(66));

    // R9 while idle
    part_en = 1'b0;
    step(2);
    blk_code = 4'd2;
    dir_up = 1'b1;
    step(1);
    blk_code = 4'd11;
    part_en = 1'b1;
    step(1);
    step(4);
    chk("R9 idle invalid ignored", com_sel, one_line(17));

    // R2 power gating
    part_en = 1'b0;
    step(2);
    pwr_off = 1'b0;
    part_en = 1'b1;
    begin
      int cnt = 0;
      for (int k = 0; k < 30; k++) begin
        step(1);
        if (scan_en) cnt++;
      end
      chk("R2 no scan with supply on", 80'(cnt), 80'd0);
      chk("R2 sel dark", com_sel, '0);
      chk("R2 lvl dark", com_lvl, '0);
    end
    pwr_off = 1'b1;
    step(5);
    chk("R2 active once supply off", com_sel, one_line(17));
    part_en = 1'b0;
    step(1);
    chk("R2 drop deselects", com_sel, '0);

    // R12 contrast
    enter(0, 1'b1);
    contrast = 3'd5;
    step(2);
    chk("R12 contrast 5", 80'(contrast_q), 80'd5);
    contrast = 3'd2;
    step(2);
    chk("R12 contrast 2", 80'(contrast_q), 80'd2);
    part_en = 1'b0;
    step(2);
    chk("R12 zero when idle", 80'(contrast_q), 80'd0);

    // R1 reset mid-operation
    enter(7, 1'b0);
    step(23);
    rst = 1'b1;
    step(1);
    chk("R1 mid reset sel", com_sel, '0);
    chk("R1 mid reset lvl", com_lvl, '0);
    chk("R1 mid reset flags", {77'd0, frame_start, scan_en, |contrast_q}, '0);
    rst = 1'b0;
    part_en = 1'b0;
    step(2);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule